// File: doc/BRIEF.md
# Multithreaded Cache Tag Timing Model

This block charges target time for the memory accesses of up to 64 interleaved target threads. It keeps no cache data. It holds only line tags, valid bits and recency ages. A functional pipeline sends one token per host cycle, and each token names a thread. An instruction that is not a load or store costs one target cycle. A retired load or store is looked up in the tag store and costs the configured hit or miss latency. The block answers each token one cycle later with a run bit. While the thread's latency is still being served, the run bit stays low and the functional side must not advance that thread.

Every visit of a thread stands for one target cycle of that thread. A per-thread countdown records how many further visits still belong to the instruction being charged. Associativity, set count, line size and both latencies live in runtime configuration registers, so the modelled geometry can change without rebuilding. A configuration write is taken only when every thread is idle, and a taken write invalidates every tag. Misses come from cold lines, capacity and conflicts. Coherence misses are not modelled.

Top module: `mt_tag_timing`

## Requirements
- R1: A response follows every input cycle one clock later: `out_valid` equals the previous `in_valid`, and `out_tid` equals the previous `in_tid` whenever that token was valid.
- R2: A charged token (valid, replay clear, thread countdown zero) costs one cycle and answers `out_run`=1 when it is not retired or when `in_inst[31:30]` is not `2'b11`. Such a token leaves the tag store unchanged.
- R3: A charged retired token with `in_inst[31:30]`=`2'b11` costs L cycles: the hit latency on a hit, the miss latency on a miss. Its own response carries run = (L==1). The thread's next L-1 non-replay tokens are stall visits, and only the last of them answers run=1.
- R4: A stall visit performs no lookup and does not modify tags or recency.
- R5: A token with `in_replay`=1 changes no countdown and no tag state. Its response has run=1 exactly when that thread's countdown is zero.
- R6: The line address is `in_paddr >> line_lg`. The set index is the low `sets_lg` bits of the line address. An access hits only when that line address is held valid in one of the first 2^`ways_lg` ways of the set.
- R7: A miss fills an invalid active way if one exists. Otherwise it replaces the least recently used active way of the set. Hits and fills both make the line most recently used.
- R8: Configuration write addresses are 0 ways_lg, 1 sets_lg, 2 line_lg, 3 hit latency and 4 miss latency. ways_lg saturates at WAY_LG, sets_lg at SET_LG and line_lg at LINE_LG_MAX. A latency of 0 is stored as 1. Addresses 5 to 7 are ignored.
- R9: A configuration write is accepted only when every thread countdown is zero and `in_valid` is low. Otherwise it is ignored.
- R10: An accepted configuration write invalidates every tag in the same clock.
- R11: After reset, `out_valid`=0 and `out_run`=0, all tags are invalid and all countdowns are zero. The geometry is 2 ways, 4 sets and 16-byte lines, with hit latency 2 and miss latency 10.
- R12: Countdowns are per thread. A charged token for one thread is not delayed by another thread's pending latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Token present this cycle |
| in_tid | input | TID_W | Target thread of the token |
| in_replay | input | 1 | Token is a replay; ignored for timing |
| in_retired | input | 1 | Instruction retired |
| in_inst | input | 32 | Instruction word; bits 31:30 equal to 2'b11 mark a load or store |
| in_paddr | input | ADDR_W | Physical address of the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | LAT_W | Configuration write value |
| out_valid | output | 1 | Response present |
| out_tid | output | TID_W | Thread of the response |
| out_run | output | 1 | Thread may advance (0 when no response) |

## Verification
The bench builds the block with its default parameters: 64 threads, up to 16 sets of up to 4 ways, line sizes up to 128 bytes and 8-bit latencies. The reset geometry of 2 ways and 4 sets makes conflict evictions and LRU order reachable with a handful of addresses 64 bytes apart. Saturating writes then reach the largest 4-way, 16-set shape. A queue-per-set recency model runs alongside the block and is compared with its outputs on every clock. A long mixed phase interleaves four thread ids, including the highest one, with replays, stall visits and configuration writes attempted both at idle and at busy moments.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
   // width of the log2 geometry fields
   localparam int unsigned LG_W = 4;
   // instruction class bits marking a load or store
   localparam logic [1:0] OP_MEM = 2'b11;

   typedef enum logic [2:0] {
      CFG_WAYS = 3'd0,
      CFG_SETS = 3'd1,
      CFG_LINE = 3'd2,
      CFG_HIT  = 3'd3,
      CFG_MISS = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/mtt_cfg.sv
module mtt_cfg
   import mtt_pkg::*;
#(
   parameter int unsigned WAY_LG      = 2,
   parameter int unsigned SET_LG      = 4,
   parameter int unsigned LINE_LG_MAX = 7,
   parameter int unsigned LAT_W       = 8,
   parameter int unsigned DEF_WAYS_LG = 1,
   parameter int unsigned DEF_SETS_LG = 2,
   parameter int unsigned DEF_LINE_LG = 4,
   parameter int unsigned DEF_HIT     = 2,
   parameter int unsigned DEF_MISS    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [LAT_W-1:0] cfg_wdata,
   input  logic             quiet,
   output logic             cfg_acc,
   output logic [LG_W-1:0]  ways_lg,
   output logic [LG_W-1:0]  sets_lg,
   output logic [LG_W-1:0]  line_lg,
   output logic [LAT_W-1:0] hit_lat,
   output logic [LAT_W-1:0] miss_lat
);
   function automatic logic [LG_W-1:0] sat_lg(input logic [LAT_W-1:0] v,
                                              input int unsigned mx);
      if (v > LAT_W'(mx)) return LG_W'(mx);
      return v[LG_W-1:0];
   endfunction

   function automatic logic [LAT_W-1:0] min_one(input logic [LAT_W-1:0] v);
      return (v == '0) ? LAT_W'(1) : v;
   endfunction

   logic addr_ok;
   assign addr_ok = (cfg_addr <= 3'(CFG_MISS));
   assign cfg_acc = cfg_we & quiet & addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ways_lg  <= LG_W'(DEF_WAYS_LG);
         sets_lg  <= LG_W'(DEF_SETS_LG);
         line_lg  <= LG_W'(DEF_LINE_LG);
         hit_lat  <= LAT_W'(DEF_HIT);
         miss_lat <= LAT_W'(DEF_MISS);
      end else if (cfg_acc) begin
         case (cfg_sel_e'(cfg_addr))
            CFG_WAYS: ways_lg  <= sat_lg(cfg_wdata, WAY_LG);
            CFG_SETS: sets_lg  <= sat_lg(cfg_wdata, SET_LG);
            CFG_LINE: line_lg  <= sat_lg(cfg_wdata, LINE_LG_MAX);
            CFG_HIT:  hit_lat  <= min_one(cfg_wdata);
            CFG_MISS: miss_lat <= min_one(cfg_wdata);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mtt_timers.sv
module mtt_timers #(
   parameter int unsigned TID_W = 6,
   parameter int unsigned LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_valid,
   input  logic [TID_W-1:0] tok_tid,
   input  logic             tok_replay,
   input  logic [LAT_W-1:0] cost,
   output logic             busy_now,
   output logic             run_resp,
   output logic             all_idle
);
   localparam int unsigned NTHR = 1 << TID_W;

   logic [LAT_W-1:0] cnt_q [NTHR];
   logic [LAT_W-1:0] cur;

   assign cur      = cnt_q[tok_tid];
   assign busy_now = (cur != '0);

   always_comb begin
      if (tok_replay)    run_resp = !busy_now;
      else if (busy_now) run_resp = (cur == LAT_W'(1));
      else               run_resp = (cost == LAT_W'(1));
   end

   always_comb begin
      all_idle = 1'b1;
      for (int t = 0; t < NTHR; t++)
         if (cnt_q[t] != '0) all_idle = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < NTHR; t++) cnt_q[t] <= '0;
      end else if (tok_valid && !tok_replay) begin
         cnt_q[tok_tid] <= busy_now ? (cur - LAT_W'(1)) : (cost - LAT_W'(1));
      end
   end
endmodule

// File: rtl/mtt_tags.sv
module mtt_tags
   import mtt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SET_LG = 4,
   parameter int unsigned WAY_LG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              upd,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [LG_W-1:0]   line_lg,
   input  logic [LG_W-1:0]   sets_lg,
   input  logic [LG_W-1:0]   ways_lg,
   output logic              hit
);
   localparam int unsigned NSETS = 1 << SET_LG;
   localparam int unsigned NWAYS = 1 << WAY_LG;
   localparam int unsigned WIX_W = (WAY_LG > 0) ? WAY_LG : 1;

   logic [ADDR_W-1:0] line;
   logic [SET_LG-1:0] set_mask, idx;
   logic [ADDR_W-1:0] tag_q [NSETS][NWAYS];
   logic [NWAYS-1:0]  vld_q [NSETS];
   logic [NWAYS-1:0]  act, hvec;
   logic [WIX_W-1:0]  sel;

   assign line = paddr >> line_lg;

   always_comb begin
      for (int i = 0; i < SET_LG; i++) set_mask[i] = (LG_W'(i) < sets_lg);
   end
   assign idx = line[SET_LG-1:0] & set_mask;

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      assign act[w]  = (32'(w) < (32'd1 << ways_lg));
      assign hvec[w] = act[w] & vld_q[idx][w] & (tag_q[idx][w] == line);
   end
   assign hit = |hvec;

   always_ff @(posedge clk) begin
      if (upd) tag_q[idx][sel] <= line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
      end else if (flush) begin
         for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
      end else if (upd) begin
         vld_q[idx][sel] <= 1'b1;
      end
   end

   if (WAY_LG == 0) begin : g_direct
      assign sel = '0;
   end else begin : g_lru
      logic [WAY_LG-1:0] age_q [NSETS][NWAYS];
      logic [WAY_LG-1:0] oldest, ref_age;
      logic              any_hit, any_inv;
      logic [WAY_LG-1:0] hit_w, inv_w, old_w;

      assign oldest = WAY_LG'((32'd1 << ways_lg) - 32'd1);

      always_comb begin
         any_hit = 1'b0;
         any_inv = 1'b0;
         hit_w   = '0;
         inv_w   = '0;
         old_w   = '0;
         for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hvec[w]) begin
               any_hit = 1'b1;
               hit_w   = WAY_LG'(w);
            end
            if (act[w] && !vld_q[idx][w]) begin
               any_inv = 1'b1;
               inv_w   = WAY_LG'(w);
            end
            if (act[w] && age_q[idx][w] == oldest) old_w = WAY_LG'(w);
         end
         if (any_hit)      sel = hit_w;
         else if (any_inv) sel = inv_w;
         else              sel = old_w;
      end

      assign ref_age = age_q[idx][sel];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < NSETS; s++)
               for (int w = 0; w < NWAYS; w++) age_q[s][w] <= WAY_LG'(w);
         end else if (flush) begin
            for (int s = 0; s < NSETS; s++)
               for (int w = 0; w < NWAYS; w++) age_q[s][w] <= WAY_LG'(w);
         end else if (upd) begin
            for (int w = 0; w < NWAYS; w++) begin
               if (act[w]) begin
                  if (WAY_LG'(w) == sel)          age_q[idx][w] <= '0;
                  else if (age_q[idx][w] < ref_age) age_q[idx][w] <= age_q[idx][w] + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mt_tag_timing.sv
module mt_tag_timing
   import mtt_pkg::*;
#(
   parameter int unsigned TID_W       = 6,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SET_LG      = 4,
   parameter int unsigned WAY_LG      = 2,
   parameter int unsigned LINE_LG_MAX = 7,
   parameter int unsigned LAT_W       = 8,
   parameter int unsigned DEF_WAYS_LG = 1,
   parameter int unsigned DEF_SETS_LG = 2,
   parameter int unsigned DEF_LINE_LG = 4,
   parameter int unsigned DEF_HIT     = 2,
   parameter int unsigned DEF_MISS    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TID_W-1:0]  in_tid,
   input  logic              in_replay,
   input  logic              in_retired,
   input  logic [31:0]       in_inst,
   input  logic [ADDR_W-1:0] in_paddr,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [LAT_W-1:0]  cfg_wdata,
   output logic              out_valid,
   output logic [TID_W-1:0]  out_tid,
   output logic              out_run
);
   if (SET_LG < 1 || SET_LG > 15) begin : g_bad_sets
      $error("SET_LG must lie in 1..15");
   end
   if (WAY_LG > 4) begin : g_bad_ways
      $error("WAY_LG must not exceed 4");
   end
   if (LAT_W < LG_W) begin : g_bad_lat
      $error("LAT_W must be at least LG_W");
   end
   if (LINE_LG_MAX >= ADDR_W || LINE_LG_MAX > 15) begin : g_bad_line
      $error("LINE_LG_MAX out of range");
   end
   if (DEF_WAYS_LG > WAY_LG || DEF_SETS_LG > SET_LG || DEF_LINE_LG > LINE_LG_MAX
       || DEF_HIT < 1 || DEF_MISS < 1) begin : g_bad_def
      $error("reset configuration outside the parameter limits");
   end

   logic             cur_busy, all_idle, run_resp, cfg_acc, quiet;
   logic             lk_hit, is_mem, charge, charge_mem;
   logic [LG_W-1:0]  ways_lg, sets_lg, line_lg;
   logic [LAT_W-1:0] hit_lat, miss_lat, cost;
   logic             unused_inst_bits;

   assign unused_inst_bits = ^in_inst[29:0];
   assign is_mem     = (in_inst[31:30] == OP_MEM);
   assign charge     = in_valid & ~in_replay & ~cur_busy;
   assign charge_mem = charge & in_retired & is_mem;
   assign cost       = charge_mem ? (lk_hit ? hit_lat : miss_lat) : LAT_W'(1);
   assign quiet      = all_idle & ~in_valid;

   mtt_cfg #(
      .WAY_LG(WAY_LG), .SET_LG(SET_LG), .LINE_LG_MAX(LINE_LG_MAX), .LAT_W(LAT_W),
      .DEF_WAYS_LG(DEF_WAYS_LG), .DEF_SETS_LG(DEF_SETS_LG), .DEF_LINE_LG(DEF_LINE_LG),
      .DEF_HIT(DEF_HIT), .DEF_MISS(DEF_MISS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .quiet(quiet), .cfg_acc(cfg_acc),
      .ways_lg(ways_lg), .sets_lg(sets_lg), .line_lg(line_lg),
      .hit_lat(hit_lat), .miss_lat(miss_lat)
   );

   mtt_timers #(.TID_W(TID_W), .LAT_W(LAT_W)) u_timers (
      .clk(clk), .rst_n(rst_n), .tok_valid(in_valid), .tok_tid(in_tid),
      .tok_replay(in_replay), .cost(cost), .busy_now(cur_busy),
      .run_resp(run_resp), .all_idle(all_idle)
   );

   mtt_tags #(.ADDR_W(ADDR_W), .SET_LG(SET_LG), .WAY_LG(WAY_LG)) u_tags (
      .clk(clk), .rst_n(rst_n), .flush(cfg_acc), .upd(charge_mem),
      .paddr(in_paddr), .line_lg(line_lg), .sets_lg(sets_lg),
      .ways_lg(ways_lg), .hit(lk_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tid   <= '0;
         out_run   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_tid   <= in_tid;
         out_run   <= in_valid & run_resp;
      end
   end
endmodule

// File: rtl/mtt_chk.sv
module mtt_chk #(
   parameter int unsigned TID_W = 6,
   parameter int unsigned LAT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [TID_W-1:0] in_tid,
   input logic             in_replay,
   input logic             out_valid,
   input logic [TID_W-1:0] out_tid,
   input logic             out_run,
   input logic             cur_busy,
   input logic             charge_mem,
   input logic             lk_hit,
   input logic [LAT_W-1:0] hit_lat,
   input logic             cfg_we,
   input logic             cfg_acc,
   input logic             all_idle
);
   // R1
   valid_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));
   // R1
   tid_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_tid == $past(in_tid)));
   // R2
   single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_replay && !cur_busy && !charge_mem) |=> out_run);
   // R3
   hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_mem && lk_hit && hit_lat > 1) |=> !out_run);
   // R5
   replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_replay && cur_busy) |=> !out_run);
   // R9
   cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (!all_idle || in_valid)) |-> !cfg_acc);
   // R11
   idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_run);
endmodule

bind mt_tag_timing mtt_chk #(.TID_W(TID_W), .LAT_W(LAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
   .in_replay(in_replay), .out_valid(out_valid), .out_tid(out_tid),
   .out_run(out_run), .cur_busy(cur_busy), .charge_mem(charge_mem),
   .lk_hit(lk_hit), .hit_lat(hit_lat), .cfg_we(cfg_we), .cfg_acc(cfg_acc),
   .all_idle(all_idle)
);

// File: tb/mt_tag_timing_bench.sv
module mt_tag_timing_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NTHR = 64;
   localparam int NSET = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_replay = 1'b0, in_retired = 1'b0;
   logic [5:0]  in_tid = '0;
   logic [31:0] in_inst = '0, in_paddr = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        out_valid, out_run;
   logic [5:0]  out_tid;

   int n_chk = 0;
   int n_err = 0;

   int cnt [NTHR];
   int m_ways = 1, m_sets = 2, m_line = 4, m_hit = 2, m_miss = 10;
   logic [31:0] lru_q [NSET][$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mt_tag_timing u_mt_tag_timing (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
      .in_replay(in_replay), .in_retired(in_retired), .in_inst(in_inst),
      .in_paddr(in_paddr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_tid(out_tid),
      .out_run(out_run)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   function automatic int model_access(input logic [31:0] pa);
      logic [31:0] ln;
      int s;
      ln = pa >> m_line;
      s = int'(ln) & ((1 << m_sets) - 1);
      for (int i = 0; i < lru_q[s].size(); i++) begin
         if (lru_q[s][i] == ln) begin
            lru_q[s].delete(i);
            lru_q[s].push_front(ln);
            return m_hit;
         end
      end
      lru_q[s].push_front(ln);
      if (lru_q[s].size() > (1 << m_ways)) void'(lru_q[s].pop_back());
      return m_miss;
   endfunction

   function automatic void model_cfg(input int a, input int d);
      case (a)
         0: m_ways = (d > 2) ? 2 : d;
         1: m_sets = (d > 4) ? 4 : d;
         2: m_line = (d > 7) ? 7 : d;
         3: m_hit  = (d == 0) ? 1 : d;
         4: m_miss = (d == 0) ? 1 : d;
         default: ;
      endcase
      for (int s = 0; s < NSET; s++) lru_q[s].delete();
   endfunction

   // one host cycle: drive at negedge, model, check at the next negedge
   task automatic cycle(input bit v, input int tid, input bit rp, input bit rt,
                        input bit mem, input logic [31:0] pa, input bit we,
                        input int ca, input int cd, input string req);
      bit e_run, quiet;
      int cost;
      in_valid   = v;
      in_tid     = tid[5:0];
      in_replay  = rp;
      in_retired = rt;
      in_inst    = {(mem ? 2'b11 : 2'b10), 30'h0ABC_1234};
      in_paddr   = pa;
      cfg_we     = we;
      cfg_addr   = ca[2:0];
      cfg_wdata  = cd[7:0];
      quiet = !v;
      for (int t = 0; t < NTHR; t++) if (cnt[t] != 0) quiet = 1'b0;
      e_run = 1'b0;
      if (v) begin
         if (rp) e_run = (cnt[tid] == 0);
         else if (cnt[tid] > 0) begin
            cnt[tid]--;
            e_run = (cnt[tid] == 0);
         end else begin
            cost = 1;
            if (rt && mem) cost = model_access(pa);
            cnt[tid] = cost - 1;
            e_run = (cnt[tid] == 0);
         end
      end
      if (we && quiet && ca <= 4) model_cfg(ca, cd);
      @(posedge clk);
      @(negedge clk);
      chk(req, "out_valid", int'(out_valid), int'(v));
      chk(req, "out_run", int'(out_run), int'(e_run));
      if (v) chk(req, "out_tid", int'(out_tid), tid);
      in_valid = 1'b0;
      cfg_we   = 1'b0;
   endtask

   task automatic drain(input int tid, input string req);
      while (cnt[tid] != 0) cycle(1, tid, 0, 1, 0, 32'h0, 0, 0, 0, req);
   endtask

   task automatic mem_op(input int tid, input logic [31:0] pa, input string req);
      cycle(1, tid, 0, 1, 1, pa, 0, 0, 0, req);
      drain(tid, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      summary();
      $finish;
   end

   initial begin
      for (int t = 0; t < NTHR; t++) cnt[t] = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "out_valid in reset", int'(out_valid), 0);
      chk("R11", "out_run in reset", int'(out_run), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cycle(0, 0, 0, 0, 0, 32'h0, 0, 0, 0, "R11");

      // R2 single-cycle tokens: non-memory and non-retired memory
      cycle(1, 3, 0, 1, 0, 32'h100, 0, 0, 0, "R2");
      cycle(1, 4, 0, 0, 1, 32'h100, 0, 0, 0, "R2");
      // R3 cold miss (not installed by the non-retired token), default miss latency
      mem_op(5, 32'h100, "R3");
      // R6 same 16-byte line hits
      mem_op(5, 32'h10C, "R6");
      // R5 replay while busy, then while idle
      cycle(1, 6, 0, 1, 1, 32'h200, 0, 0, 0, "R5");
      cycle(1, 6, 1, 1, 1, 32'h300, 0, 0, 0, "R5");
      cycle(1, 6, 1, 1, 1, 32'h300, 0, 0, 0, "R5");
      drain(6, "R4");
      cycle(1, 6, 1, 1, 1, 32'h400, 0, 0, 0, "R5");
      mem_op(6, 32'h400, "R5");
      // R4 stall visits carry an address that must not be installed
      cycle(1, 9, 0, 1, 1, 32'h500, 0, 0, 0, "R4");
      cycle(1, 9, 0, 1, 1, 32'h600, 0, 0, 0, "R4");
      drain(9, "R4");
      mem_op(9, 32'h600, "R4");
      // R7 LRU in set 0 of 2 ways x 4 sets: A B A C A B
      mem_op(1, 32'h000, "R7");
      mem_op(1, 32'h040, "R7");
      mem_op(1, 32'h000, "R7");
      mem_op(1, 32'h080, "R7");
      mem_op(1, 32'h000, "R7");
      mem_op(1, 32'h040, "R7");
      // R12 other thread proceeds while thread 7 is busy
      cycle(1, 7, 0, 1, 1, 32'h700, 0, 0, 0, "R12");
      cycle(1, 8, 0, 1, 0, 32'h0, 0, 0, 0, "R12");
      cycle(1, 63, 0, 1, 1, 32'h040, 0, 0, 0, "R12");
      drain(63, "R12");
      // R9 write while a thread is busy is ignored
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 3, 5, "R9");
      drain(7, "R9");
      // R9 write together with a valid token is ignored
      cycle(1, 2, 0, 1, 0, 32'h0, 1, 3, 6, "R9");
      mem_op(1, 32'h040, "R9");
      // R8 unused address ignored; line stays cached
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 6, 0, "R8");
      mem_op(1, 32'h040, "R8");
      // R10 accepted write flushes: a known line misses again
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 3, 3, "R10");
      mem_op(1, 32'h040, "R10");
      mem_op(1, 32'h040, "R10");
      // R8 saturation and latency floor
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 0, 9, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 1, 15, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 2, 12, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 3, 0, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 4, 0, "R8");
      mem_op(2, 32'h1000, "R8");
      mem_op(2, 32'h1000, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 4, 4, "R8");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 3, 2, "R8");
      // R7 four-way LRU over 16 sets of 128-byte lines
      for (int i = 0; i < 6; i++) mem_op(3, 32'(i) << 11, "R7");
      for (int i = 0; i < 6; i++) mem_op(3, 32'(5 - i) << 11, "R7");
      // R12 mixed interleaved traffic
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 1, 2, "R12");
      cycle(0, 0, 0, 0, 0, 32'h0, 1, 2, 4, "R12");
      for (int n = 0; n < 4000; n++) begin
         int r, tid, k;
         bit v, rp, rt, mem, we;
         r   = int'($urandom_range(0, 3));
         tid = (r == 3) ? 63 : r;
         v   = ($urandom_range(0, 9) != 0);
         rp  = ($urandom_range(0, 9) == 0);
         rt  = ($urandom_range(0, 7) != 0);
         mem = ($urandom_range(0, 2) != 0);
         we  = ($urandom_range(0, 19) == 0);
         k   = int'($urandom_range(0, 7));
         cycle(v, tid, rp, rt, mem, 32'($urandom_range(0, 255)) << 4, we, k,
               (k == 0) ? int'($urandom_range(0, 3)) :
               (k < 3) ? int'($urandom_range(1, 5)) : int'($urandom_range(0, 6)),
               "R12");
      end
      summary();
      $finish;
   end
endmodule